// File: doc/BRIEF.md
# Nesting Vectored Interrupt Controller

This block gathers 32 level-sensitive interrupt sources and presents them to a processor on two outputs: a fast line and a normal line. Each source is pending when its input pin is high or its software-raise bit is set. A fast-select mask steers each source to one output or the other. An enable mask gates only the normal path.

Up to 16 sources can be placed in ordered vector slots. Slot 0 is the most urgent. Each slot holds a handler address, and one shared fallback address serves requests with no slot. Software begins a handler by reading the current-vector register. That read returns the address and raises the active masking level to the slot being served. Software finishes the handler by writing the same register, which drops the level back to where it was before.

A hardware table of saved levels makes the nesting automatic. While a handler runs, only sources in more urgent slots can assert the normal line. Register access uses a plain single-cycle bus with read and write strobes, a byte address and 32-bit data.

Top module: `vecint_ctrl`

## Requirements
- R1: A source's raw state is its pin OR its software-raise bit. Writing ones at 0x18 sets software-raise bits and writing ones at 0x1C clears them. Reading 0x08 gives the raw state and reading 0x18 gives the software-raise bits.
- R2: Writing ones at 0x10 sets enable bits and writing ones at 0x14 clears them. Zero bits leave their enable bits unchanged. Reading 0x10 gives the enable mask.
- R3: The fast-select mask is read and written at 0x0C. Reading 0x00 gives raw AND enable AND NOT fast-select. Reading 0x04 gives raw AND fast-select.
- R4: `fiq_o` is a register. It is high one clock after any source is both raw-pending and fast-selected.
- R5: `irq_o` is a register, updated one clock after its inputs change.
  - At the idle level, it is high when any bit of the 0x00 status is set.
  - At slot level L, it is high only for a 0x00 status bit whose source is owned by an enabled slot with an index below L.
- R6: Slot s has its control at 0x200+4*s and its handler address at 0x100+4*s.
  - In the control, bit 5 enables the slot and bits 4:0 name its source.
  - A control read returns bits 5:0 only.
  - The fallback address is at 0x34.
- R7: A read of 0x30 picks the lowest-index enabled slot that meets both of these conditions:
  - its index is below the active level;
  - its source has its 0x00 status bit set.
  
  The read returns that slot's address, saves the old level, and makes the slot the active level. If no slot qualifies, the read returns the fallback address and the level is unchanged.
- R8: Any write to 0x30 returns the active level to the level saved when it was entered, regardless of the data. Such a write at idle has no effect.
- R9: Reset is synchronous and active high. It clears every mask, every slot address and control, the fallback address, the protection bit and both outputs, and it sets the level to idle.
- R10: Writes to 0x00 and to undefined offsets change nothing. Reads of undefined offsets return zero.
- R11: Reading offsets 0xFE0 to 0xFFC, one byte per word, returns 0x90, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R12: Bit 0 at 0x20 is a read/write flag. The other bits of that word read as zero.
- R13: `bus_rdata` is registered and is valid the clock after `bus_rd`. A read strobe in a cycle that also has a write strobe is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| src_in | input | 32 | Interrupt source pins |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
Two actions can meet in one clock: the level raise caused by a vector read, and the re-evaluation of `irq_o` against the sources that are pending. The bench keeps a less urgent source pending while it reads the vector of a more urgent one. It judges `irq_o` one clock after the read data appears, so the new level must already mask the lower source. It also raises a more urgent source at a nested level and expects `irq_o` to return in the next clock. In addition, it checks that a fast-selected source is never chosen by the vector search.

// File: rtl/vecint_pkg.sv
package vecint_pkg;

  localparam logic [11:0] OFS_NSTAT  = 12'h000;
  localparam logic [11:0] OFS_FSTAT  = 12'h004;
  localparam logic [11:0] OFS_RAW    = 12'h008;
  localparam logic [11:0] OFS_FSEL   = 12'h00C;
  localparam logic [11:0] OFS_ENSET  = 12'h010;
  localparam logic [11:0] OFS_ENCLR  = 12'h014;
  localparam logic [11:0] OFS_SWSET  = 12'h018;
  localparam logic [11:0] OFS_SWCLR  = 12'h01C;
  localparam logic [11:0] OFS_PROT   = 12'h020;
  localparam logic [11:0] OFS_VEC    = 12'h030;
  localparam logic [11:0] OFS_DEFV   = 12'h034;
  localparam logic [11:0] OFS_SADDR  = 12'h100;
  localparam logic [11:0] OFS_SCTL   = 12'h200;
  localparam logic [11:0] OFS_IDBASE = 12'hFE0;

  function automatic logic [7:0] id_byte(input logic [2:0] i);
    case (i)
      3'd0:    return 8'h90;
      3'd1:    return 8'h11;
      3'd2:    return 8'h04;
      3'd3:    return 8'h00;
      3'd4:    return 8'h0D;
      3'd5:    return 8'hF0;
      3'd6:    return 8'h05;
      default: return 8'hB1;
    endcase
  endfunction

endpackage

// File: rtl/vecint_prio.sv
module vecint_prio #(
  parameter int NSRC  = 32,
  parameter int NSLOT = 16,
  parameter int SW    = 5,
  parameter int LW    = 5,
  parameter int IDLE  = 17
) (
  input  logic [NSLOT-1:0] slot_on,
  input  logic [SW-1:0]    slot_src [NSLOT],
  input  logic [NSRC-1:0]  nstat,
  input  logic [LW-1:0]    level,
  output logic             hit,
  output logic [LW-1:0]    hit_slot,
  output logic [NSRC-1:0]  above_mask
);

  logic [NSLOT-1:0] cand;

  // each slot qualifies when enabled, its source pending and it ranks above the level
  for (genvar s = 0; s < NSLOT; s++) begin : g_cand
    assign cand[s] = slot_on[s] && nstat[slot_src[s]] && (LW'(s) < level);
  end

  always_comb begin
    hit      = 1'b0;
    hit_slot = '0;
    for (int s = NSLOT - 1; s >= 0; s--) begin
      if (cand[s]) begin
        hit      = 1'b1;
        hit_slot = LW'(s);
      end
    end
  end

  always_comb begin
    if (level == LW'(IDLE)) begin
      above_mask = '1;
    end else begin
      above_mask = '0;
      for (int s = 0; s < NSLOT; s++) begin
        if (slot_on[s] && (LW'(s) < level)) above_mask[slot_src[s]] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/vecint_stack.sv
module vecint_stack #(
  parameter int NLVL = 17,
  parameter int LW   = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [LW-1:0] push_lvl,
  input  logic          pop,
  output logic [LW-1:0] level
);

  localparam logic [LW-1:0] IDLE = LW'(NLVL);

  // saved level per active level; no reset so it maps onto distributed RAM
  logic [LW-1:0] saved [NLVL];

  always_ff @(posedge clk) begin
    if (push) saved[push_lvl] <= level;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level <= IDLE;
    end else if (push) begin
      level <= push_lvl;
    end else if (pop && level != IDLE) begin
      level <= saved[level];
    end
  end

  AST_PUSH_RAISES: assert property (@(posedge clk) disable iff (rst)
    push |=> level < $past(level)); // R7
  AST_IDLE_POP: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && level == IDLE) |=> level == IDLE); // R8

endmodule

// File: rtl/vecint_ctrl.sv
module vecint_ctrl
  import vecint_pkg::*;
#(
  parameter int NSRC  = 32,
  parameter int NSLOT = 16,
  parameter int DW    = 32,
  parameter int AW    = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_rd,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [NSRC-1:0] src_in,
  output logic            irq_o,
  output logic            fiq_o
);

  localparam int SW   = $clog2(NSRC);
  localparam int SIW  = $clog2(NSLOT);
  localparam int NLVL = NSLOT + 1;
  localparam int LW   = $clog2(NLVL + 1);
  localparam int IDLE = NLVL;

  logic [NSRC-1:0] en_q, sw_q, fsel_q;
  logic            prot_q;
  logic [DW-1:0]   defv_q;
  logic [DW-1:0]   slot_addr [NSLOT];
  logic [NSLOT-1:0] slot_on;
  logic [SW-1:0]   slot_src [NSLOT];

  logic [NSRC-1:0] raw, nstat, fstat, above_mask;
  logic            hit;
  logic [LW-1:0]   hit_slot, act_lvl;
  logic [DW-1:0]   rd_val;

  wire rd_eff   = bus_rd && !bus_wr;
  wire in_saddr = bus_addr >= AW'(OFS_SADDR) && bus_addr < AW'(OFS_SADDR + 4 * NSLOT);
  wire in_sctl  = bus_addr >= AW'(OFS_SCTL)  && bus_addr < AW'(OFS_SCTL + 4 * NSLOT);
  wire in_id    = bus_addr >= AW'(OFS_IDBASE);
  wire [SIW-1:0] sidx = bus_addr[SIW+1:2];

  assign raw   = src_in | sw_q;
  assign nstat = raw & en_q & ~fsel_q;
  assign fstat = raw & fsel_q;

  wire push = rd_eff && bus_addr == AW'(OFS_VEC) && hit;
  wire pop  = bus_wr && bus_addr == AW'(OFS_VEC);

  vecint_prio #(.NSRC(NSRC), .NSLOT(NSLOT), .SW(SW), .LW(LW), .IDLE(IDLE)) u_prio (
    .slot_on(slot_on), .slot_src(slot_src), .nstat(nstat), .level(act_lvl),
    .hit(hit), .hit_slot(hit_slot), .above_mask(above_mask)
  );

  vecint_stack #(.NLVL(NLVL), .LW(LW)) u_stack (
    .clk(clk), .rst(rst), .push(push), .push_lvl(hit_slot), .pop(pop), .level(act_lvl)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= '0;
      sw_q    <= '0;
      fsel_q  <= '0;
      prot_q  <= 1'b0;
      defv_q  <= '0;
      slot_on <= '0;
      for (int s = 0; s < NSLOT; s++) begin
        slot_addr[s] <= '0;
        slot_src[s]  <= '0;
      end
    end else if (bus_wr) begin
      if (in_saddr) begin
        slot_addr[sidx] <= bus_wdata;
      end else if (in_sctl) begin
        slot_on[sidx]  <= bus_wdata[SW];
        slot_src[sidx] <= bus_wdata[SW-1:0];
      end else begin
        case (bus_addr)
          AW'(OFS_FSEL):  fsel_q <= bus_wdata[NSRC-1:0];
          AW'(OFS_ENSET): en_q   <= en_q | bus_wdata[NSRC-1:0];
          AW'(OFS_ENCLR): en_q   <= en_q & ~bus_wdata[NSRC-1:0];
          AW'(OFS_SWSET): sw_q   <= sw_q | bus_wdata[NSRC-1:0];
          AW'(OFS_SWCLR): sw_q   <= sw_q & ~bus_wdata[NSRC-1:0];
          AW'(OFS_PROT):  prot_q <= bus_wdata[0];
          AW'(OFS_DEFV):  defv_q <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_val = '0;
    if (in_saddr) begin
      rd_val = slot_addr[sidx];
    end else if (in_sctl) begin
      rd_val = DW'({slot_on[sidx], slot_src[sidx]});
    end else if (in_id) begin
      rd_val = DW'(id_byte(bus_addr[4:2]));
    end else begin
      case (bus_addr)
        AW'(OFS_NSTAT): rd_val = DW'(nstat);
        AW'(OFS_FSTAT): rd_val = DW'(fstat);
        AW'(OFS_RAW):   rd_val = DW'(raw);
        AW'(OFS_FSEL):  rd_val = DW'(fsel_q);
        AW'(OFS_ENSET): rd_val = DW'(en_q);
        AW'(OFS_SWSET): rd_val = DW'(sw_q);
        AW'(OFS_PROT):  rd_val = DW'(prot_q);
        AW'(OFS_VEC):   rd_val = hit ? slot_addr[hit_slot[SIW-1:0]] : defv_q;
        AW'(OFS_DEFV):  rd_val = defv_q;
        default:        rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_o     <= 1'b0;
      fiq_o     <= 1'b0;
    end else begin
      if (rd_eff) bus_rdata <= rd_val;
      irq_o <= |(nstat & above_mask);
      fiq_o <= |fstat;
    end
  end

  AST_FIQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> fiq_o == $past(|((src_in | sw_q) & fsel_q))); // R4
  AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (rst)
    (act_lvl == LW'(IDLE) && |nstat) |=> irq_o); // R5
  AST_ID_READ: assert property (@(posedge clk) disable iff (rst)
    (rd_eff && bus_addr == AW'(OFS_IDBASE)) |=> bus_rdata == DW'(8'h90)); // R11
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rd_eff |=> $stable(bus_rdata)); // R13

endmodule

// File: tb/test_vecint_ctrl.sv
module test_vecint_ctrl;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] src_in = '0;
  logic        irq_o, fiq_o;

  int nchk = 0;
  int nerr = 0;

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t exp_q[$];
  logic  rd_seen = 1'b0;

  always #5 clk = ~clk;

  vecint_ctrl i_vecint_ctrl (
    .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_in(src_in),
    .irq_o(irq_o), .fiq_o(fiq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // driver: issues a read and queues the value the requirements predict
  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back('{exp, tag});
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic set_src(input logic [31:0] v);
    @(negedge clk);
    src_in = v;
    settle();
  endtask

  // monitor: compares read data the clock after the strobe (R13)
  always @(posedge clk) rd_seen <= bus_rd;
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      item_t it;
      it = exp_q.pop_front();
      chk(it.tag, bus_rdata, it.exp);
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    chk("R9 irq_o", 32'(irq_o), 0);
    chk("R9 fiq_o", 32'(fiq_o), 0);
    rd(12'h000, 0, "R9 status");
    rd(12'h034, 0, "R9 fallback");
    rd(12'h100, 0, "R9 slot addr");
    rd(12'h200, 0, "R9 slot ctl");
    // R11 identification
    rd(12'hFE0, 32'h90, "R11 id0");
    rd(12'hFF4, 32'hF0, "R11 id5");
    rd(12'hFFC, 32'hB1, "R11 id7");
    // R12 protection flag
    wr(12'h020, 32'hFFFF);
    rd(12'h020, 32'h1, "R12 prot");
    // R2 enable set/clear
    wr(12'h010, 32'h0000_00FF);
    wr(12'h014, 32'h0000_000F);
    rd(12'h010, 32'h0000_00F0, "R2 enable");
    // R1 raw and software raise
    @(negedge clk); src_in = 32'h10;
    wr(12'h018, 32'h100);
    rd(12'h008, 32'h110, "R1 raw");
    rd(12'h018, 32'h100, "R1 soft");
    wr(12'h01C, 32'h100);
    rd(12'h018, 32'h0, "R1 soft clear");
    // R3 status split
    @(negedge clk); src_in = 32'h30;
    wr(12'h00C, 32'h20);
    rd(12'h000, 32'h10, "R3 normal");
    rd(12'h004, 32'h20, "R3 fast");
    rd(12'h00C, 32'h20, "R3 fsel");
    chk("R4 fiq_o", 32'(fiq_o), 1);
    chk("R5 irq idle", 32'(irq_o), 1);
    // R10 ignored writes and undefined offsets
    wr(12'h000, 32'hFFFF_FFFF);
    rd(12'h000, 32'h10, "R10 write to status");
    wr(12'h024, 32'hFFFF_FFFF);
    rd(12'h010, 32'hF0, "R10 undefined write");
    rd(12'h040, 32'h0, "R10 undefined read");
    wr(12'h00C, 32'h0);
    set_src(32'h0);
    chk("R4 fiq low", 32'(fiq_o), 0);
    chk("R5 irq low", 32'(irq_o), 0);
    // R6 slot set-up
    wr(12'h010, 32'hFFFF_FFFF);
    wr(12'h200, 32'h23);
    wr(12'h208, 32'hE7);
    wr(12'h214, 32'h29);
    wr(12'h100, 32'hA0);
    wr(12'h108, 32'hA2);
    wr(12'h114, 32'hA5);
    wr(12'h034, 32'hDEF);
    rd(12'h208, 32'h27, "R6 ctl bits");
    rd(12'h114, 32'hA5, "R6 slot addr");
    rd(12'h034, 32'hDEF, "R6 fallback");
    // R7 fast-selected source is not vectored
    wr(12'h00C, 32'h200);
    set_src(32'h200);
    rd(12'h030, 32'hDEF, "R7 fast not vectored");
    wr(12'h00C, 32'h0);
    settle();
    chk("R5 idle slot src", 32'(irq_o), 1);
    // R7 nesting
    rd(12'h030, 32'hA5, "R7 enter slot5");
    settle();
    chk("R5 masked at 5", 32'(irq_o), 0);
    set_src(32'h280);
    chk("R5 higher at 5", 32'(irq_o), 1);
    rd(12'h030, 32'hA2, "R7 enter slot2");
    settle();
    chk("R5 masked at 2", 32'(irq_o), 0);
    rd(12'h030, 32'hDEF, "R7 none above");
    settle();
    chk("R7 level kept", 32'(irq_o), 0);
    set_src(32'h288);
    chk("R7 still at 2", 32'(irq_o), 1);
    rd(12'h030, 32'hA0, "R7 enter slot0");
    settle();
    chk("R5 masked at 0", 32'(irq_o), 0);
    // R8 unwinding
    wr(12'h030, 32'h1234_5678);
    settle();
    chk("R8 back to 2", 32'(irq_o), 1);
    set_src(32'h200);
    chk("R8 at 2 lower", 32'(irq_o), 0);
    wr(12'h030, 32'h0);
    settle();
    chk("R8 back to 5", 32'(irq_o), 0);
    wr(12'h030, 32'h0);
    settle();
    chk("R8 back to idle", 32'(irq_o), 1);
    set_src(32'h0010_0000);
    chk("R5 unvectored idle", 32'(irq_o), 1);
    wr(12'h030, 32'h0);
    settle();
    chk("R8 idle pop", 32'(irq_o), 1);
    rd(12'h030, 32'hDEF, "R7 unvectored");
    settle();
    chk("R7 idle kept", 32'(irq_o), 1);
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

endmodule